// File: doc/BRIEF.md
# Two-Window Address Relocation and Protection Unit

This block maps program-relative addresses from a user process onto the physical word memory of a 36-bit machine. A process sees an 18-bit address space. The top address bit splits that space into two windows, low and high. Each window has its own register pair. The origin register gives the physical word that window offset zero lands on. The limit register gives the largest offset the window may touch. The high window is meant to hold a region that several processes share. It can be marked read-only.

Each request is translated in one clock cycle. The unit picks a window, checks the offset against that window's limit and, for writes to the high window, against its read-only mark. If the checks pass, the unit adds the origin and returns a valid physical address. If a check fails, it raises a violation instead of a valid result. Supervisor-mode references skip all of this and are returned unchanged, zero-extended to the physical width. Window registers are written through a load port, which is honoured only in a cycle with no request.

Top module: `dsr_reloc_top`

## Requirements
- R1: After reset all outputs are 0, and both windows hold origin 0, limit 0 and no read-only mark. So a user request to offset 0 of either window is valid with physical address 0, and a user request to offset 1 is a violation.
- R2: In user mode, request address bit 17 selects the window (0 = low, 1 = high). Bits 16:0 form the offset, so the selector bit plays no part in the compare or the add.
- R3: A user request that passes the checks produces out_valid=1 and out_phys = origin + offset, taken modulo 2^22. The result appears in the cycle after the request.
- R4: A user request whose offset is greater than the selected limit gives out_viol=1 and out_valid=0 in the result cycle. An offset equal to the limit is legal.
- R5: A user write to the high window while its read-only mark is set gives out_viol=1 and out_valid=0. Reads of a marked high window are not affected, and writes to the low window are never blocked by the mark.
- R6: A supervisor-mode request (req_user=0) gives out_valid=1, out_viol=0 and out_phys equal to req_addr zero-extended to 22 bits, whatever the window registers hold.
- R7: With ld_en=1 and req_valid=0, the window chosen by ld_high (0 = low, 1 = high) takes ld_base, ld_bound and, for the high window only, ld_wprot. The new values apply to a request in the very next cycle. A load in a cycle with req_valid=1 is dropped.
- R8: A cycle with no request gives out_valid=0 and out_viol=0 in the next cycle. Whenever out_valid is 0, out_phys is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 18 | Program-relative address; bit 17 selects the window |
| req_write | input | 1 | 1 = write reference, 0 = read |
| req_user | input | 1 | 1 = user mode (checked and relocated), 0 = supervisor mode |
| ld_en | input | 1 | Window register load strobe |
| ld_high | input | 1 | Load target: 0 = low window, 1 = high window |
| ld_base | input | 22 | Origin value to load |
| ld_bound | input | 17 | Limit value to load |
| ld_wprot | input | 1 | Read-only mark to load (high window only) |
| out_valid | output | 1 | Translated address is valid |
| out_phys | output | 22 | Physical word address; 0 when not valid |
| out_viol | output | 1 | Protection violation for the previous request |

## Verification
The checker assumes that every control input is a known 0 or 1 at each rising edge and that req_addr is known whenever req_valid is high. Its supervisor-mode property takes the result one edge after the request, so it relies on the default registered output stage. The bench drives every input on the falling edge and samples results just after the rising edge, so each input is settled when the checker sees it. Loads are issued in idle cycles, except for one deliberate collision that exercises the dropped-load case.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   localparam int DSR_VA_W_DEF = 18;
   localparam int DSR_PA_W_DEF = 22;

   typedef enum logic {
      WIN_LOW  = 1'b0,
      WIN_HIGH = 1'b1
   } win_sel_e;

endpackage

// File: rtl/dsr_seg_bank.sv
module dsr_seg_bank #(
   parameter int OFF_W = 17,
   parameter int PA_W  = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic             ld_high,
   input  logic [PA_W-1:0]  ld_base,
   input  logic [OFF_W-1:0] ld_bound,
   input  logic             ld_wprot,
   input  logic             busy,
   input  logic             rd_high,
   output logic [PA_W-1:0]  rd_base,
   output logic [OFF_W-1:0] rd_bound,
   output logic             rd_wprot
);
   import dsr_pkg::*;

   localparam int NWIN = 2;

   logic             ld_ok;
   logic [PA_W-1:0]  base_v  [NWIN];
   logic [OFF_W-1:0] bound_v [NWIN];
   logic             wp_v    [NWIN];

   assign ld_ok = ld_en && !busy;

   generate
      for (genvar g = 0; g < NWIN; g++) begin : g_win
         logic [PA_W-1:0]  base_q;
         logic [OFF_W-1:0] bound_q;
         logic             hit;

         assign hit = ld_ok && (ld_high == ((g == 1) ? WIN_HIGH : WIN_LOW));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               base_q  <= '0;
               bound_q <= '0;
            end else if (hit) begin
               base_q  <= ld_base;
               bound_q <= ld_bound;
            end
         end

         if (g == 1) begin : g_wp
            logic wp_q;
            always_ff @(posedge clk) begin
               if (!rst_n)   wp_q <= 1'b0;
               else if (hit) wp_q <= ld_wprot;
            end
            assign wp_v[g] = wp_q;
         end else begin : g_nowp
            assign wp_v[g] = 1'b0;
         end

         assign base_v[g]  = base_q;
         assign bound_v[g] = bound_q;
      end
   endgenerate

   assign rd_base  = rd_high ? base_v[1]  : base_v[0];
   assign rd_bound = rd_high ? bound_v[1] : bound_v[0];
   assign rd_wprot = rd_high ? wp_v[1]    : wp_v[0];

endmodule

// File: rtl/dsr_xlate.sv
module dsr_xlate #(
   parameter int VA_W = 18,
   parameter int PA_W = 22
) (
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_addr,
   input  logic              req_write,
   input  logic              req_user,
   input  logic [PA_W-1:0]   win_base,
   input  logic [VA_W-2:0]   win_bound,
   input  logic              win_wprot,
   output logic              nx_valid,
   output logic              nx_viol,
   output logic [PA_W-1:0]   nx_phys
);
   localparam int OFF_W = VA_W - 1;

   logic             is_high;
   logic [OFF_W-1:0] offset;
   logic             over_limit;
   logic             wr_fault;

   assign is_high    = req_addr[VA_W-1];
   assign offset     = req_addr[OFF_W-1:0];
   assign over_limit = offset > win_bound;
   assign wr_fault   = is_high && req_write && win_wprot;

   always_comb begin
      nx_valid = 1'b0;
      nx_viol  = 1'b0;
      nx_phys  = '0;
      if (req_valid) begin
         if (!req_user) begin
            nx_valid = 1'b1;
            nx_phys  = PA_W'(req_addr);
         end else if (over_limit || wr_fault) begin
            nx_viol = 1'b1;
         end else begin
            nx_valid = 1'b1;
            nx_phys  = win_base + PA_W'(offset);
         end
      end
   end

endmodule

// File: rtl/dsr_out_stage.sv
module dsr_out_stage #(
   parameter int PA_W    = 22,
   parameter bit OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            nx_valid,
   input  logic            nx_viol,
   input  logic [PA_W-1:0] nx_phys,
   output logic            out_valid,
   output logic            out_viol,
   output logic [PA_W-1:0] out_phys
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_viol  <= 1'b0;
               out_phys  <= '0;
            end else begin
               out_valid <= nx_valid;
               out_viol  <= nx_viol;
               out_phys  <= nx_phys;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign out_valid  = nx_valid;
         assign out_viol   = nx_viol;
         assign out_phys   = nx_phys;
      end
   endgenerate

endmodule

// File: rtl/dsr_reloc_top.sv
module dsr_reloc_top #(
   parameter int VA_W    = dsr_pkg::DSR_VA_W_DEF,
   parameter int PA_W    = dsr_pkg::DSR_PA_W_DEF,
   parameter bit OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [VA_W-1:0] req_addr,
   input  logic            req_write,
   input  logic            req_user,
   input  logic            ld_en,
   input  logic            ld_high,
   input  logic [PA_W-1:0] ld_base,
   input  logic [VA_W-2:0] ld_bound,
   input  logic            ld_wprot,
   output logic            out_valid,
   output logic [PA_W-1:0] out_phys,
   output logic            out_viol
);
   localparam int OFF_W = VA_W - 1;

   generate
      if (VA_W < 2) begin : g_bad_va
         $error("dsr_reloc_top: VA_W must be at least 2");
      end
      if (PA_W < VA_W) begin : g_bad_pa
         $error("dsr_reloc_top: PA_W must not be narrower than VA_W");
      end
   endgenerate

   logic [PA_W-1:0]  win_base;
   logic [OFF_W-1:0] win_bound;
   logic             win_wprot;
   logic             nx_valid;
   logic             nx_viol;
   logic [PA_W-1:0]  nx_phys;

   dsr_seg_bank #(.OFF_W(OFF_W), .PA_W(PA_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .ld_high  (ld_high),
      .ld_base  (ld_base),
      .ld_bound (ld_bound),
      .ld_wprot (ld_wprot),
      .busy     (req_valid),
      .rd_high  (req_addr[VA_W-1]),
      .rd_base  (win_base),
      .rd_bound (win_bound),
      .rd_wprot (win_wprot)
   );

   dsr_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_write (req_write),
      .req_user  (req_user),
      .win_base  (win_base),
      .win_bound (win_bound),
      .win_wprot (win_wprot),
      .nx_valid  (nx_valid),
      .nx_viol   (nx_viol),
      .nx_phys   (nx_phys)
   );

   dsr_out_stage #(.PA_W(PA_W), .OUT_REG(OUT_REG)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .nx_valid  (nx_valid),
      .nx_viol   (nx_viol),
      .nx_phys   (nx_phys),
      .out_valid (out_valid),
      .out_viol  (out_viol),
      .out_phys  (out_phys)
   );

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
   parameter int VA_W    = 18,
   parameter int PA_W    = 22,
   parameter bit OUT_REG = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [VA_W-1:0] req_addr,
   input logic            req_user,
   input logic            out_valid,
   input logic            out_viol,
   input logic [PA_W-1:0] out_phys
);
   logic [PA_W-1:0] addr_ext;
   assign addr_ext = {{(PA_W-VA_W){1'b0}}, req_addr};

   // R4: a violation never comes with a valid result
   a_r4_viol_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_viol |-> !out_valid);

   // R8: an invalid result carries a zero address
   a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_phys == '0));

   generate
      if (OUT_REG) begin : g_seq
         // R8: an idle cycle yields an empty result next cycle
         a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> (!out_valid && !out_viol));

         // R6: supervisor requests pass through unchanged
         a_r6_exec_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_user) |=>
               (out_valid && !out_viol && out_phys == $past(addr_ext)));
      end
   endgenerate

endmodule

bind dsr_reloc_top dsr_checker #(.VA_W(VA_W), .PA_W(PA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .req_user  (req_user),
   .out_valid (out_valid),
   .out_viol  (out_viol),
   .out_phys  (out_phys)
);

// File: tb/sim_dsr_reloc_top.sv
module sim_dsr_reloc_top;
   localparam int CLK_PERIOD = 10;
   localparam int VA_W = 18;
   localparam int PA_W = 22;
   localparam int OFF_W = VA_W - 1;
   localparam int WD_CYCLES = 20000;

   typedef struct {
      logic            v;
      logic            viol;
      logic [PA_W-1:0] phys;
      string           tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [VA_W-1:0] req_addr = '0;
   logic            req_write = 1'b0;
   logic            req_user = 1'b0;
   logic            ld_en = 1'b0;
   logic            ld_high = 1'b0;
   logic [PA_W-1:0] ld_base = '0;
   logic [OFF_W-1:0] ld_bound = '0;
   logic            ld_wprot = 1'b0;
   logic            out_valid;
   logic [PA_W-1:0] out_phys;
   logic            out_viol;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   exp_t q[$];

   logic [PA_W-1:0]  m_base [2];
   logic [OFF_W-1:0] m_bound[2];
   logic             m_wp;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsr_reloc_top u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_user(req_user), .ld_en(ld_en), .ld_high(ld_high),
      .ld_base(ld_base), .ld_bound(ld_bound), .ld_wprot(ld_wprot),
      .out_valid(out_valid), .out_phys(out_phys), .out_viol(out_viol)
   );

   task automatic check(input string tag, input logic v, input logic viol,
                        input logic [PA_W-1:0] phys);
      checks++;
      if (out_valid !== v || out_viol !== viol || out_phys !== phys) begin
         fails++;
         $display("FAIL %s: got valid=%0b viol=%0b phys=%06h, expected valid=%0b viol=%0b phys=%06h",
                  tag, out_valid, out_viol, out_phys, v, viol, phys);
      end
   endtask

   // Driver: one call per cycle, pushes the expected result
   task automatic drive(input string tag, input logic rq, input logic [VA_W-1:0] a,
                        input logic wr, input logic usr, input logic ld,
                        input logic ldh, input logic [PA_W-1:0] b,
                        input logic [OFF_W-1:0] bd, input logic wp);
      exp_t e;
      logic hi;
      logic [OFF_W-1:0] off;
      @(negedge clk);
      req_valid = rq; req_addr = a; req_write = wr; req_user = usr;
      ld_en = ld; ld_high = ldh; ld_base = b; ld_bound = bd; ld_wprot = wp;
      e.tag = tag; e.v = 1'b0; e.viol = 1'b0; e.phys = '0;
      hi  = a[VA_W-1];
      off = a[OFF_W-1:0];
      if (rq) begin
         if (!usr) begin
            e.v = 1'b1; e.phys = PA_W'(a);
         end else if (off > m_bound[hi] || (hi && wr && m_wp)) begin
            e.viol = 1'b1;
         end else begin
            e.v = 1'b1; e.phys = m_base[hi] + PA_W'(off);
         end
      end
      q.push_back(e);
      if (ld && !rq) begin
         m_base[ldh] = b; m_bound[ldh] = bd;
         if (ldh) m_wp = wp;
      end
   endtask

   task automatic req(input string tag, input logic [VA_W-1:0] a,
                      input logic wr, input logic usr);
      drive(tag, 1'b1, a, wr, usr, 1'b0, 1'b0, '0, '0, 1'b0);
   endtask

   task automatic load(input string tag, input logic ldh, input logic [PA_W-1:0] b,
                       input logic [OFF_W-1:0] bd, input logic wp);
      drive(tag, 1'b0, '0, 1'b0, 1'b0, 1'b1, ldh, b, bd, wp);
   endtask

   task automatic idle(input string tag);
      drive(tag, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
   endtask

   // Monitor: pops the item latched at this edge, compares after update
   always @(posedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         #1;
         check(e.tag, e.v, e.viol, e.phys);
      end
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [17:0] lfsr;
      m_base[0] = '0; m_base[1] = '0; m_bound[0] = '0; m_bound[1] = '0; m_wp = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset outputs", 1'b0, 1'b0, '0);

      // R1: reset register contents
      req("R1 low offset 0", 18'h00000, 1'b0, 1'b1);
      req("R1 low offset 1", 18'h00001, 1'b0, 1'b1);
      req("R1 high offset 0", 18'h20000, 1'b1, 1'b1);
      idle("R8 idle after reset");

      // R7: loads, then back-to-back use
      load("R7 load low", 1'b0, 22'h001000, 17'h000FF, 1'b1);
      req("R7 new low values next cycle", 18'h00010, 1'b0, 1'b1);
      load("R7 load high", 1'b1, 22'h3F0000, 17'h1FFFF, 1'b1);

      // R2/R3/R4: selection, add, limit
      req("R3 low offset 0", 18'h00000, 1'b0, 1'b1);
      req("R4 low at limit", 18'h000FF, 1'b0, 1'b1);
      req("R4 low above limit", 18'h00100, 1'b0, 1'b1);
      req("R2 high selector stripped", 18'h20000, 1'b0, 1'b1);
      req("R3 high wrap modulo", 18'h3FFFF, 1'b0, 1'b1);

      // R5: read-only high window
      req("R5 write protected high", 18'h20004, 1'b1, 1'b1);
      req("R5 write low unaffected", 18'h00004, 1'b1, 1'b1);
      req("R5 read protected high", 18'h20004, 1'b0, 1'b1);

      // R6: supervisor bypass
      req("R6 exec top address", 18'h3FFFF, 1'b1, 1'b0);
      req("R6 exec beyond limit", 18'h00100, 1'b0, 1'b0);

      // R7: load during a request is dropped
      drive("R7 load with request dropped", 1'b1, 18'h00020, 1'b0, 1'b1,
            1'b1, 1'b0, 22'h000500, 17'h00010, 1'b0);
      req("R7 old low values kept", 18'h00020, 1'b0, 1'b1);
      load("R7 clear high protect", 1'b1, 22'h100000, 17'h00040, 1'b0);
      req("R5 write unprotected high", 18'h20040, 1'b1, 1'b1);
      req("R4 high above new limit", 18'h20041, 1'b0, 1'b1);
      idle("R8 idle");
      idle("R8 idle second");

      // Mixed sweep
      load("R7 sweep low", 1'b0, 22'h2FFF00, 17'h0FFFF, 1'b0);
      load("R7 sweep high", 1'b1, 22'h0ABCDE, 17'h08000, 1'b1);
      lfsr = 18'h2B3C1;
      for (int i = 0; i < 48; i++) begin
         lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
         if (i % 7 == 6) idle("R8 sweep idle");
         else req("R3 sweep", lfsr, lfsr[3], (i % 5) != 0);
      end
      idle("R8 drain");
      idle("R8 drain");
      while (q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule